// File: doc/BRIEF.md
# Reset Source Controller with Clock-Loss Detection

This block merges every reason a chip may need to restart into one active-high system reset and keeps a record of which reason acted last. Three causes are watched: an active-low external reset pin, a comparator output from a supply monitor, and a detector that notices when the system clock has stopped toggling. A power-on input clears the whole block and also produces a reset pulse. Once every cause has gone away, the system reset stays asserted for a fixed number of reference cycles, so each reset pulse has a minimum width.

The clock-loss detector runs from a free-running reference clock that is independent of the system clock. It brings the system clock level into the reference domain through a three-flop chain and restarts a cycle counter on every level change it sees. If no change arrives for a programmed number of reference cycles, the system clock counts as stuck, whether it stopped high or low. All logic, including the register port, runs in the reference domain. This keeps the register port alive while the system clock is stopped.

Software uses a small register port with a write strobe, a read strobe, an 8-bit address and 8-bit data. It reaches two registers. The cause register reads back as one-hot cause flags, and a write to two of its bits sets enables instead. The supply register holds the monitor enable and shows the live supply status. The pin and supply inputs are taken to be filtered already and synchronous to the reference clock.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, `sys_rst` is 1 from the first reference edge that samples it low. After that reset, cause register bit 0 reads 1 and bits 1 and 2 read 0.
- R2: `sys_rst` stays 1 for HOLD_CYC more reference edges after the first edge that sees no active cause and no `por`. It reads 0 after the HOLD_CYC+1-th such edge.
- R3: With the clock-loss detector enabled, a system clock that holds one level for about LOSS_CYC reference cycles asserts `sys_rst`. A clock that is still toggling never does. Afterwards, cause register bit 2 reads 1 and the other flag bits read 0.
- R4: Writing 1 to cause register bit 2 enables the clock-loss detector, and writing 0 disables it. While it is disabled, a stopped system clock causes no reset. Reading bit 2 returns the clock-loss flag, not the enable.
- R5: The supply monitor causes a reset only when three things hold: supply register bit 7 (enable) is 1, cause register bit 1 (select, write side) is 1, and `supply_ok` is 0. Afterwards, cause register bit 1 reads 1.
- R6: In the supply register, bit 7 reads the enable and bit 6 reads the live `supply_ok`. Bits 5:0 read 0, and writes to them have no effect.
- R7: When several causes are active in the same cycle, only one flag is set, chosen by fixed priority: supply first, then pin, then clock loss. The flags always show the cause chosen in the last cycle in which any cause was active.
- R8: Register writes made while `sys_rst` is 1 are ignored.
- R9: `por` asserts `sys_rst`. It clears all flags, the supply enable, the supply select and the clock-loss enable.
- R10: `sfr_rdata` is 0 when `sfr_rd` is low or when the address matches neither register (cause register 0xE1, supply register 0xE2).
- R11: When a stopped system clock starts toggling again, the clock-loss cause clears within a few reference cycles. `sys_rst` is then released after the hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all logic |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_clk | input | 1 | System clock being watched (asynchronous level) |
| rst_pin_n | input | 1 | External reset pin, active low |
| supply_ok | input | 1 | Supply comparator: 1 when above threshold |
| sfr_wr | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| sys_rst | output | 1 | System reset, active high |

## Verification
The hardest case to reach is one where two causes overlap and one of them cannot be removed at once. Clock loss is like this: it only ends a few synchronizer cycles after the system clock toggles again. The bench therefore freezes the gated system clock to trigger the detector, pulls the pin low on top of it, and restarts the clock while the pin is still held. It then releases the pin, which shows that the priority and the "last active cause" rule leave the pin flag set. The bench also checks the detection window from both sides by sampling just before and just after the loss count.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_SUPPLY = 2'd1,
        CAUSE_PIN    = 2'd2,
        CAUSE_CLK    = 2'd3
    } cause_e;

    typedef struct packed {
        logic supply;
        logic pin;
        logic clk;
    } cause_vec_t;

    typedef struct packed {
        logic vmon_en;
        logic sup_sel;
        logic loss_en;
    } ctrl_t;

    localparam int FLAG_PIN_BIT  = 0;
    localparam int FLAG_SUP_BIT  = 1;
    localparam int FLAG_CLK_BIT  = 2;
    localparam int VMON_EN_BIT   = 7;
    localparam int VMON_STAT_BIT = 6;

    function automatic cause_e pick_cause(input cause_vec_t v);
        if (v.supply)   return CAUSE_SUPPLY;
        else if (v.pin) return CAUSE_PIN;
        else if (v.clk) return CAUSE_CLK;
        else            return CAUSE_NONE;
    endfunction

    function automatic cause_vec_t cause_onehot(input cause_e c);
        cause_vec_t r;
        r = '0;
        case (c)
            CAUSE_SUPPLY: r.supply = 1'b1;
            CAUSE_PIN:    r.pin    = 1'b1;
            CAUSE_CLK:    r.clk    = 1'b1;
            default:      r        = '0;
        endcase
        return r;
    endfunction

    function automatic logic any_cause(input cause_vec_t v);
        return v.supply | v.pin | v.clk;
    endfunction

endpackage

// File: rtl/rstc_clk_monitor.sv
module rstc_clk_monitor #(
    parameter int LOSS_CYC = 5000,
    localparam int CW = $clog2(LOSS_CYC + 1)
) (
    input  logic clk,
    input  logic por,
    input  logic sys_clk,
    input  logic enable,
    output logic lost
);
    logic [2:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          toggled;

    always_ff @(posedge clk) begin
        if (por) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], sys_clk};
    end

    assign toggled = sync_q[2] ^ sync_q[1];

    always_ff @(posedge clk) begin
        if (por || !enable || toggled)
            cnt_q <= '0;
        else if (cnt_q != CW'(LOSS_CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    assign lost = enable && (cnt_q == CW'(LOSS_CYC));

    // R11
    toggle_clears_loss_chk: assert property (@(posedge clk) disable iff (por)
        toggled |=> !lost);

    // R4
    disable_quiets_loss_chk: assert property (@(posedge clk) disable iff (por)
        !enable |=> (cnt_q == '0));

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int HOLD_CYC = 16,
    localparam int CW = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic por,
    input  logic cause_any,
    output logic sys_rst
);
    logic [CW-1:0] hold_q;
    logic          rst_q;

    always_ff @(posedge clk) begin
        if (por || cause_any) begin
            hold_q <= CW'(HOLD_CYC);
            rst_q  <= 1'b1;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            rst_q  <= 1'b1;
        end else begin
            rst_q  <= 1'b0;
        end
    end

    assign sys_rst = rst_q;

    // R2
    cause_asserts_rst_chk: assert property (@(posedge clk) disable iff (por)
        cause_any |=> sys_rst);

    // R2
    release_after_quiet_chk: assert property (@(posedge clk) disable iff (por)
        $fell(sys_rst) |-> !$past(cause_any));

endmodule

// File: rtl/rstc_sfr.sv
module rstc_sfr
    import rstc_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SRC_ADDR  = 'hE1,
    parameter logic [ADDR_W-1:0] VMON_ADDR = 'hE2
) (
    input  logic              clk,
    input  logic              por,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              supply_ok,
    input  cause_vec_t        active,
    output logic [7:0]        rd_data,
    output ctrl_t             ctrl
);
    cause_vec_t flags_q;
    ctrl_t      ctrl_q;
    logic       wr_ok;
    logic [7:0] src_byte;
    logic [7:0] vmon_byte;
    logic       unused_wbits;

    assign wr_ok = wr_en && !sys_rst;
    assign unused_wbits = ^{wr_data[6:3], wr_data[0]};

    always_ff @(posedge clk) begin
        if (por) begin
            ctrl_q <= '0;
        end else if (wr_ok) begin
            if (addr == SRC_ADDR) begin
                ctrl_q.sup_sel <= wr_data[FLAG_SUP_BIT];
                ctrl_q.loss_en <= wr_data[FLAG_CLK_BIT];
            end
            if (addr == VMON_ADDR)
                ctrl_q.vmon_en <= wr_data[VMON_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (por)
            flags_q <= '0;
        else if (any_cause(active))
            flags_q <= cause_onehot(pick_cause(active));
    end

    always_comb begin
        src_byte = '0;
        src_byte[FLAG_PIN_BIT] = flags_q.pin;
        src_byte[FLAG_SUP_BIT] = flags_q.supply;
        src_byte[FLAG_CLK_BIT] = flags_q.clk;
        vmon_byte = '0;
        vmon_byte[VMON_EN_BIT]   = ctrl_q.vmon_en;
        vmon_byte[VMON_STAT_BIT] = supply_ok;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (addr == SRC_ADDR)       rd_data = src_byte;
            else if (addr == VMON_ADDR) rd_data = vmon_byte;
        end
    end

    assign ctrl = ctrl_q;

    // R7
    single_flag_chk: assert property (@(posedge clk) disable iff (por)
        $onehot0(flags_q));

    // R8
    write_blocked_chk: assert property (@(posedge clk) disable iff (por)
        (sys_rst && wr_en) |=> $stable(ctrl_q));

    // R6
    vmon_low_zero_chk: assert property (@(posedge clk) disable iff (por)
        (rd_en && addr == VMON_ADDR) |-> (rd_data[5:0] == 6'd0));

endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
    import rstc_pkg::*;
#(
    parameter int LOSS_CYC = 5000,
    parameter int HOLD_CYC = 16,
    parameter int ADDR_W   = 8
) (
    input  logic              ref_clk,
    input  logic              por,
    input  logic              sys_clk,
    input  logic              rst_pin_n,
    input  logic              supply_ok,
    input  logic              sfr_wr,
    input  logic              sfr_rd,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    output logic              sys_rst
);
    ctrl_t      ctrl;
    cause_vec_t active;
    logic       clk_lost;

    rstc_clk_monitor #(.LOSS_CYC(LOSS_CYC)) u_mon (
        .clk     (ref_clk),
        .por     (por),
        .sys_clk (sys_clk),
        .enable  (ctrl.loss_en),
        .lost    (clk_lost)
    );

    always_comb begin
        active.supply = ctrl.vmon_en & ctrl.sup_sel & ~supply_ok;
        active.pin    = ~rst_pin_n;
        active.clk    = clk_lost;
    end

    rstc_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
        .clk       (ref_clk),
        .por       (por),
        .cause_any (any_cause(active)),
        .sys_rst   (sys_rst)
    );

    rstc_sfr #(.ADDR_W(ADDR_W)) u_sfr (
        .clk       (ref_clk),
        .por       (por),
        .sys_rst   (sys_rst),
        .wr_en     (sfr_wr),
        .rd_en     (sfr_rd),
        .addr      (sfr_addr),
        .wr_data   (sfr_wdata),
        .supply_ok (supply_ok),
        .active    (active),
        .rd_data   (sfr_rdata),
        .ctrl      (ctrl)
    );

    // R1
    pin_forces_rst_chk: assert property (@(posedge ref_clk) disable iff (por)
        !rst_pin_n |=> sys_rst);

endmodule

// File: tb/rst_source_ctrl_test.sv
module rst_source_ctrl_test;
    localparam int LOSS = 40;
    localparam int HOLD = 8;
    localparam logic [7:0] A_SRC  = 8'hE1;
    localparam logic [7:0] A_VMON = 8'hE2;
    localparam int NV = 12;
    // entry: [20] write, [19:12] address, [11:4] data or expected, [3:0] requirement
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'hE1, 8'h00, 4'd9},
        {1'b0, 8'hE2, 8'h40, 4'd6},
        {1'b1, 8'hE2, 8'hFF, 4'd6},
        {1'b0, 8'hE2, 8'hC0, 4'd6},
        {1'b1, 8'hE2, 8'h3F, 4'd6},
        {1'b0, 8'hE2, 8'h40, 4'd6},
        {1'b1, 8'hE1, 8'h06, 4'd4},
        {1'b0, 8'hE1, 8'h00, 4'd4},
        {1'b1, 8'h10, 8'hFF, 4'd10},
        {1'b0, 8'h10, 8'h00, 4'd10},
        {1'b1, 8'hE1, 8'h00, 4'd4},
        {1'b0, 8'hE2, 8'h40, 4'd6}
    };

    logic ref_clk = 0, por = 1, sys_clk = 0, rst_pin_n = 1, supply_ok = 1;
    logic sfr_wr = 0, sfr_rd = 0;
    logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
    logic sys_rst, sys_run = 1, done = 0;
    int checks = 0, fails = 0;

    rst_source_ctrl #(.LOSS_CYC(LOSS), .HOLD_CYC(HOLD)) uut (
        .ref_clk(ref_clk), .por(por), .sys_clk(sys_clk), .rst_pin_n(rst_pin_n),
        .supply_ok(supply_ok), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sys_rst(sys_rst));

    always #10 ref_clk = ~ref_clk;
    always begin
        #13;
        if (sys_run) sys_clk = ~sys_clk;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge ref_clk);
        sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
        @(negedge ref_clk);
        sfr_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge ref_clk);
        sfr_rd = 1; sfr_addr = a;
        #5 d = sfr_rdata;
        sfr_rd = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        // R9 power-on state, R2 hold width
        cyc(3);
        chk("R9 rst during por", {7'd0, sys_rst}, 8'd1);
        por = 0;
        cyc(HOLD);
        chk("R2 rst held", {7'd0, sys_rst}, 8'd1);
        cyc(1);
        chk("R2 rst released", {7'd0, sys_rst}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) wr(VEC[i][19:12], VEC[i][11:4]);
            else rd_chk($sformatf("R%0d table %0d", VEC[i][3:0], i), VEC[i][19:12], VEC[i][11:4]);
        end

        // R1 pin reset
        rst_pin_n = 0;
        cyc(1);
        chk("R1 pin asserts rst", {7'd0, sys_rst}, 8'd1);
        cyc(3);
        rst_pin_n = 1;
        cyc(HOLD + 2);
        chk("R1 rst ends", {7'd0, sys_rst}, 8'd0);
        rd_chk("R1 pin flag", A_SRC, 8'h01);
        // R10 read strobe low
        sfr_addr = A_SRC;
        #5 chk("R10 rd low gives zero", sfr_rdata, 8'h00);

        // R5 supply reset
        wr(A_VMON, 8'h80);
        wr(A_SRC, 8'h02);
        supply_ok = 0;
        cyc(1);
        chk("R5 supply asserts rst", {7'd0, sys_rst}, 8'd1);
        rd_chk("R6 status low enable high", A_VMON, 8'h80);
        cyc(2);
        supply_ok = 1;
        cyc(HOLD + 2);
        chk("R5 rst ends", {7'd0, sys_rst}, 8'd0);
        rd_chk("R5 supply flag", A_SRC, 8'h02);
        wr(A_SRC, 8'h00);
        supply_ok = 0;
        cyc(6);
        chk("R5 unselected no rst", {7'd0, sys_rst}, 8'd0);
        supply_ok = 1;
        wr(A_VMON, 8'h00);
        wr(A_SRC, 8'h02);
        supply_ok = 0;
        cyc(6);
        chk("R5 disabled no rst", {7'd0, sys_rst}, 8'd0);
        supply_ok = 1;

        // R7 supply and pin together
        wr(A_VMON, 8'h80);
        supply_ok = 0; rst_pin_n = 0;
        cyc(4);
        supply_ok = 1; rst_pin_n = 1;
        cyc(HOLD + 2);
        rd_chk("R7 supply beats pin", A_SRC, 8'h02);
        wr(A_VMON, 8'h00);

        // R7 pin over clock loss
        wr(A_SRC, 8'h04);
        sys_run = 0;
        cyc(LOSS + 8);
        chk("R3 loss asserts rst", {7'd0, sys_rst}, 8'd1);
        rst_pin_n = 0;
        cyc(3);
        sys_run = 1;
        cyc(10);
        rst_pin_n = 1;
        cyc(HOLD + 2);
        chk("R7 rst ends", {7'd0, sys_rst}, 8'd0);
        rd_chk("R7 pin beats loss", A_SRC, 8'h01);

        // R3 clock loss window, R11 recovery
        sys_run = 0;
        cyc(LOSS - 2);
        chk("R3 no rst before window", {7'd0, sys_rst}, 8'd0);
        cyc(10);
        chk("R3 rst after window", {7'd0, sys_rst}, 8'd1);
        sys_run = 1;
        cyc(2);
        chk("R11 rst still held", {7'd0, sys_rst}, 8'd1);
        cyc(HOLD + 6);
        chk("R11 rst released", {7'd0, sys_rst}, 8'd0);
        rd_chk("R3 loss flag", A_SRC, 8'h04);

        // R4 detector disabled
        wr(A_SRC, 8'h00);
        sys_run = 0;
        cyc(LOSS + 20);
        chk("R4 disabled no rst", {7'd0, sys_rst}, 8'd0);
        rd_chk("R4 bit2 shows flag", A_SRC, 8'h04);
        sys_run = 1;
        cyc(5);

        // R8 writes blocked during reset
        rst_pin_n = 0;
        cyc(1);
        wr(A_VMON, 8'h80);
        wr(A_SRC, 8'h06);
        rst_pin_n = 1;
        cyc(HOLD + 2);
        rd_chk("R8 vmon write ignored", A_VMON, 8'h40);
        sys_run = 0;
        cyc(LOSS + 10);
        chk("R8 src write ignored", {7'd0, sys_rst}, 8'd0);
        sys_run = 1;
        cyc(5);

        // R9 mid-run power-on clears state
        wr(A_VMON, 8'h80);
        wr(A_SRC, 8'h06);
        por = 1;
        cyc(2);
        chk("R9 por asserts rst", {7'd0, sys_rst}, 8'd1);
        por = 0;
        cyc(HOLD + 2);
        rd_chk("R9 flags cleared", A_SRC, 8'h00);
        rd_chk("R9 enable cleared", A_VMON, 8'h40);
        supply_ok = 0;
        cyc(4);
        chk("R9 select cleared", {7'd0, sys_rst}, 8'd0);
        supply_ok = 1;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule